// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block is the address side of a single DMA channel. Software fills a small set of registers: a base address, an element count and a signed byte stride for the inner (row) loop, a row count and a signed row stride for the outer loop, and a 16-bit control word. Once the control word is written with its run bit set, the channel issues one memory address per beat on a valid/ready request port until the pattern is finished. It then flags completion in a status register that software clears by writing ones.

The control word selects the transfer direction, the element size (1, 2 or 4 bytes), flat or two-dimensional walking, a flush bit, an interrupt mode, and two descriptor-related fields. The descriptor fields are only stored, so the channel always stops after one pattern. The live address and the remaining inner and outer counts can be read back at any time. A stride of zero holds the address fixed, which suits a peripheral data port. Negative strides walk downward through memory.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, req_valid and irq are 0, and the status, live address, live inner count and live outer count read back as 0.
- R2: Writing the control word (offset 5) with bit 0 set while bit 0 was clear arms the channel. In the cycle after that write, the live inner count (offset 9) and live outer count (offset 10) read 0 and req_valid is 0. From the following cycle req_valid is 1 and req_addr equals the base address (offset 0).
- R3: With control bit 4 clear (flat mode), the channel issues inner-count (offset 1) addresses. Each address is the previous one plus the signed inner stride (offset 2). Right after the first address appears, the live inner count reads the programmed inner count.
- R4: With control bit 4 set (2D mode), each row holds inner-count addresses spaced by the inner stride. The address after the last element of a row is that element plus the signed row stride (offset 4), which replaces the inner stride for that step. The pattern ends after outer-count (offset 3) rows.
- R5: A stride of 0 repeats the same address, and a negative 16-bit stride lowers the address.
- R6: An inner or outer count programmed as 0 is taken as 65536.
- R7: Done (status bit 0, offset 6) reads 1 in the cycle after the final address is accepted. req_valid stays 0 from then on.
- R8: irq is 1 while a status bit is set and the interrupt mode (control bits 7:6) is nonzero. With interrupt mode 0, irq stays 0 even when done is set.
- R9: Writing offset 6 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R10: An element size code (control bits 3:2) of 3, or an address not aligned to the element size (code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), sets error (status bit 1). The channel stops with no beat issued for that address.
- R11: Writing the control word with bit 0 clear halts the channel. req_valid is 0 in the cycle after the write and stays 0.
- R12: While control bit 5 is set, the channel stays flushed: the live address and both live counts read 0 and no beat is issued.
- R13: While req_valid is 1 and req_ready is 0, req_addr holds its value and req_valid stays 1. req_write follows control bit 1 and req_width follows control bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register offset for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Register offset for the read |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| req_valid | output | 1 | An address beat is offered |
| req_ready | input | 1 | The beat is accepted on this edge |
| req_addr | output | 32 | Byte address of the beat |
| req_width | output | 2 | Element size code of the beat |
| req_write | output | 1 | 1 when the beat writes to memory |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted loop counter changes the length of the pattern. It shows on the ports as a wrong address at the first row turn, or as done arriving one or more beats early or late. The bench sees this within one pattern because it compares every issued address against its own model. A wrong control state shows up within two cycles of the write that causes it, as a beat during arming, halting or flushing, or as a missing beat. A broken status path shows in the cycle after the final beat, through the done bit and irq.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int DMA_AW = 32;
  localparam int DMA_CW = 16;
  localparam int DMA_DW = 32;

  localparam logic [3:0] OFS_BASE   = 4'd0;
  localparam logic [3:0] OFS_ICNT   = 4'd1;
  localparam logic [3:0] OFS_ISTEP  = 4'd2;
  localparam logic [3:0] OFS_OCNT   = 4'd3;
  localparam logic [3:0] OFS_OSTEP  = 4'd4;
  localparam logic [3:0] OFS_CTRL   = 4'd5;
  localparam logic [3:0] OFS_STAT   = 4'd6;
  localparam logic [3:0] OFS_LADDR  = 4'd8;
  localparam logic [3:0] OFS_LICNT  = 4'd9;
  localparam logic [3:0] OFS_LOCNT  = 4'd10;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN, ST_STOP} walk_state_t;

  // 2'b11 is the illegal size code
  function automatic logic size_ok(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    size_ok = 1'b1;
      2'd1:    size_ok = ~lo[0];
      2'd2:    size_ok = (lo == 2'b00);
      default: size_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [DMA_AW-1:0] add_stride(input logic [DMA_AW-1:0] a,
                                                   input logic [DMA_CW-1:0] s);
    add_stride = a + {{(DMA_AW-DMA_CW){s[DMA_CW-1]}}, s};
  endfunction

  function automatic logic [DMA_CW:0] count_of(input logic [DMA_CW-1:0] c);
    count_of = (c == '0) ? {1'b1, {DMA_CW{1'b0}}} : {1'b0, c};
  endfunction
endpackage

// File: rtl/dma2d_regs.sv
module dma2d_regs
  import dma2d_pkg::*;
#(
  parameter int AW = DMA_AW,
  parameter int CW = DMA_CW,
  parameter int DW = DMA_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] live_addr,
  input  logic [CW:0]   live_icnt,
  input  logic [CW:0]   live_ocnt,
  input  logic          done_set,
  input  logic          err_set,
  output logic [AW-1:0] base_q,
  output logic [CW-1:0] icnt_q,
  output logic [CW-1:0] istep_q,
  output logic [CW-1:0] ocnt_q,
  output logic [CW-1:0] ostep_q,
  output logic [15:0]   ctrl_q,
  output logic [1:0]    stat_q,
  output logic          arm_evt,
  output logic          halt_evt,
  output logic          flush_evt
);
  logic ctrl_wr, stat_wr;
  assign ctrl_wr = wr_en && (wr_sel == OFS_CTRL);
  assign stat_wr = wr_en && (wr_sel == OFS_STAT);

  assign arm_evt   = ctrl_wr && wr_data[0] && !ctrl_q[0];
  assign halt_evt  = ctrl_wr && !wr_data[0];
  assign flush_evt = (ctrl_wr && wr_data[5]) || ctrl_q[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      icnt_q  <= '0;
      istep_q <= '0;
      ocnt_q  <= '0;
      ostep_q <= '0;
      ctrl_q  <= '0;
      stat_q  <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          OFS_BASE:  base_q  <= wr_data[AW-1:0];
          OFS_ICNT:  icnt_q  <= wr_data[CW-1:0];
          OFS_ISTEP: istep_q <= wr_data[CW-1:0];
          OFS_OCNT:  ocnt_q  <= wr_data[CW-1:0];
          OFS_OSTEP: ostep_q <= wr_data[CW-1:0];
          OFS_CTRL:  ctrl_q  <= wr_data[15:0];
          default: ;
        endcase
      end
      stat_q <= (stat_q & ~(stat_wr ? wr_data[1:0] : 2'b00)) | {err_set, done_set};
    end
  end

  always_comb begin
    case (rd_sel)
      OFS_BASE:  rd_data = DW'(base_q);
      OFS_ICNT:  rd_data = DW'(icnt_q);
      OFS_ISTEP: rd_data = DW'(istep_q);
      OFS_OCNT:  rd_data = DW'(ocnt_q);
      OFS_OSTEP: rd_data = DW'(ostep_q);
      OFS_CTRL:  rd_data = DW'(ctrl_q);
      OFS_STAT:  rd_data = DW'(stat_q);
      OFS_LADDR: rd_data = DW'(live_addr);
      OFS_LICNT: rd_data = DW'(live_icnt[CW-1:0]);
      OFS_LOCNT: rd_data = DW'(live_ocnt[CW-1:0]);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
  import dma2d_pkg::*;
#(
  parameter int AW = DMA_AW,
  parameter int CW = DMA_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_evt,
  input  logic          halt_evt,
  input  logic          flush_evt,
  input  logic [AW-1:0] base_q,
  input  logic [CW-1:0] icnt_q,
  input  logic [CW-1:0] istep_q,
  input  logic [CW-1:0] ocnt_q,
  input  logic [CW-1:0] ostep_q,
  input  logic [1:0]    size_code,
  input  logic          two_d,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] live_addr,
  output logic [CW:0]   live_icnt,
  output logic [CW:0]   live_ocnt,
  output logic          done_set,
  output logic          err_set
);
  walk_state_t state_q;
  logic ctl_override, addr_ok, accept, row_end, last_beat;

  assign ctl_override = flush_evt || halt_evt || arm_evt;
  assign addr_ok   = size_ok(size_code, live_addr[1:0]);
  assign req_valid = (state_q == ST_RUN) && addr_ok;
  assign accept    = req_valid && req_ready;
  assign row_end   = (live_icnt == (CW+1)'(1));
  assign last_beat = row_end && (live_ocnt == (CW+1)'(1));

  assign done_set = !ctl_override && accept && last_beat;
  assign err_set  = !ctl_override &&
                    (((state_q == ST_ARM) && (size_code == 2'd3)) ||
                     ((state_q == ST_RUN) && !addr_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      live_addr <= '0;
      live_icnt <= '0;
      live_ocnt <= '0;
    end else if (flush_evt) begin
      state_q   <= ST_IDLE;
      live_addr <= '0;
      live_icnt <= '0;
      live_ocnt <= '0;
    end else if (halt_evt) begin
      state_q <= ST_IDLE;
    end else if (arm_evt) begin
      state_q   <= ST_ARM;
      live_icnt <= '0;
      live_ocnt <= '0;
    end else begin
      case (state_q)
        ST_ARM: begin
          if (size_code == 2'd3) begin
            state_q <= ST_STOP;
          end else begin
            state_q   <= ST_RUN;
            live_addr <= base_q;
            live_icnt <= count_of(icnt_q);
            live_ocnt <= two_d ? count_of(ocnt_q) : (CW+1)'(1);
          end
        end
        ST_RUN: begin
          if (!addr_ok) begin
            state_q <= ST_STOP;
          end else if (accept) begin
            if (last_beat) begin
              state_q <= ST_STOP;
            end else if (row_end) begin
              live_addr <= add_stride(live_addr, ostep_q);
              live_icnt <= count_of(icnt_q);
              live_ocnt <= live_ocnt - 1'b1;
            end else begin
              live_addr <= add_stride(live_addr, istep_q);
              live_icnt <= live_icnt - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = DMA_AW,
  parameter int CW = DMA_CW,
  parameter int DW = DMA_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_width,
  output logic          req_write,
  output logic          irq
);
  logic [AW-1:0] base_q, live_addr;
  logic [CW-1:0] icnt_q, istep_q, ocnt_q, ostep_q;
  logic [15:0]   ctrl_q;
  logic [1:0]    stat_q;
  logic [CW:0]   live_icnt, live_ocnt;
  logic arm_evt, halt_evt, flush_evt, done_set, err_set;

  dma2d_regs #(.AW(AW), .CW(CW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .live_addr(live_addr),
    .live_icnt(live_icnt), .live_ocnt(live_ocnt), .done_set(done_set),
    .err_set(err_set), .base_q(base_q), .icnt_q(icnt_q), .istep_q(istep_q),
    .ocnt_q(ocnt_q), .ostep_q(ostep_q), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .arm_evt(arm_evt), .halt_evt(halt_evt), .flush_evt(flush_evt)
  );

  dma2d_walker #(.AW(AW), .CW(CW)) walk_i (
    .clk(clk), .rst_n(rst_n), .arm_evt(arm_evt), .halt_evt(halt_evt),
    .flush_evt(flush_evt), .base_q(base_q), .icnt_q(icnt_q), .istep_q(istep_q),
    .ocnt_q(ocnt_q), .ostep_q(ostep_q), .size_code(ctrl_q[3:2]),
    .two_d(ctrl_q[4]), .req_ready(req_ready), .req_valid(req_valid),
    .live_addr(live_addr), .live_icnt(live_icnt), .live_ocnt(live_ocnt),
    .done_set(done_set), .err_set(err_set)
  );

  assign req_addr  = live_addr;
  assign req_width = ctrl_q[3:2];
  assign req_write = ctrl_q[1];
  assign irq       = (ctrl_q[7:6] != 2'b00) && (stat_q != 2'b00);
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_width,
  input logic          arm_evt,
  input logic          halt_evt,
  input logic          flush_evt,
  input logic          done_set,
  input logic          err_set,
  input logic [CW:0]   live_icnt,
  input logic [AW-1:0] live_addr
);
  p_hold_on_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !halt_evt && !flush_evt && !arm_evt)
      |=> (req_valid && $stable(req_addr)));

  p_arm_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_evt && !flush_evt) |=> (!req_valid && live_icnt == '0));

  p_done_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |-> (req_valid && req_ready));

  p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> !req_valid);

  p_err_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> !req_valid);

  p_beat_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_width != 2'd3) && !(req_width == 2'd1 && req_addr[0]) &&
                  !(req_width == 2'd2 && req_addr[1:0] != 2'b00));

  p_halt_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_evt && !arm_evt) |=> !req_valid);

  p_flush_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (!req_valid && live_addr == '0 && live_icnt == '0));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_width(req_width), .arm_evt(arm_evt),
  .halt_evt(halt_evt), .flush_evt(flush_evt), .done_set(done_set),
  .err_set(err_set), .live_icnt(live_icnt), .live_addr(live_addr)
);

// File: tb/dma2d_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma2d_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] rd_sel = '0;
  logic [31:0] rd_data;
  logic req_valid, req_ready, req_write, irq;
  logic [31:0] req_addr;
  logic [1:0] req_width;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma2d_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_width(req_width),
    .req_write(req_write), .irq(irq)
  );

  // fields: base, inner count, inner stride, outer count, outer stride, control
  localparam int NV = 5;
  localparam logic [111:0] VEC [NV] = '{
    {32'h0000_1000, 16'd4, 16'h0001, 16'd0, 16'h0000, 16'h0041},
    {32'h0000_2000, 16'd3, 16'h0004, 16'd0, 16'h0000, 16'h004B},
    {32'h0000_3000, 16'd3, 16'h0002, 16'd2, 16'h0010, 16'h0055},
    {32'h0000_4100, 16'd2, 16'hFFFC, 16'd3, 16'hFFF8, 16'h0059},
    {32'h0000_5004, 16'd5, 16'h0000, 16'd0, 16'h0000, 16'h0049}
  };

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] sel, output logic [31:0] d);
    rd_sel = sel;
    #0.1;
    d = rd_data;
  endtask

  task automatic setup(input logic [31:0] b, input logic [15:0] ic, input logic [15:0] is,
                       input logic [15:0] oc, input logic [15:0] os);
    wr(4'd0, b); wr(4'd1, {16'd0, ic}); wr(4'd2, {16'd0, is});
    wr(4'd3, {16'd0, oc}); wr(4'd4, {16'd0, os});
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (req_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic cleanup();
    wr(4'd5, 32'h0);
    wr(4'd6, 32'h3);
  endtask

  // full pattern with ready held high; every address compared with the model
  task automatic run_pattern(input logic [31:0] b, input logic [15:0] ic,
                             input logic [15:0] is, input logic [15:0] oc,
                             input logic [15:0] os, input logic [15:0] ctl,
                             input string req, input bit per_beat);
    logic [31:0] r, a;
    int cols, rows, bad, beats;
    bit seen;
    setup(b, ic, is, oc, os);
    req_ready = 1'b1;
    wr(4'd5, {16'd0, ctl});
    rd(4'd9, r);
    chk(r == 0 && !req_valid, "R2 armed counts zero", {r[30:0], req_valid}, 32'h0);
    @(negedge clk);
    chk(req_valid && req_addr == b, "R2 first address", req_addr, b);
    rd(4'd9, r);
    chk(r[15:0] == ic, "R3 live inner count", r, {16'd0, ic});
    cols = (ic == 0) ? 65536 : int'(ic);
    rows = ctl[4] ? ((oc == 0) ? 65536 : int'(oc)) : 1;
    a = b; bad = 0; beats = 0;
    for (int y = 0; y < rows; y++) begin
      for (int x = 0; x < cols; x++) begin
        wait_valid(seen);
        if (!seen || req_addr != a) begin
          bad++;
          if (per_beat) chk(1'b0, req, req_addr, a);
        end else if (per_beat) begin
          chk(1'b1, req, req_addr, a);
        end
        chk(req_width == ctl[3:2] && req_write == ctl[1], "R13 width/dir",
            {29'd0, req_width, req_write}, {29'd0, ctl[3:1]});
        beats++;
        if (x == cols - 1) a = a + {{16{os[15]}}, os};
        else               a = a + {{16{is[15]}}, is};
        @(negedge clk);
      end
    end
    if (!per_beat) chk(bad == 0, req, bad, 0);
    rd(4'd6, r);
    chk(r[0] == 1'b1 && !req_valid, "R7 done after last beat", {r[30:0], req_valid}, 32'h2);
    chk(irq == (ctl[7:6] != 0), "R8 irq vs mode", {31'd0, irq}, {31'd0, ctl[7:6] != 0});
    @(negedge clk);
    chk(!req_valid, "R7 stays quiet", {31'd0, req_valid}, 0);
    cleanup();
  endtask

  initial begin
    logic [31:0] r, a0;
    bit seen;
    req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd6, r);  chk(r == 0, "R1 status", r, 0);
    rd(4'd8, r);  chk(r == 0, "R1 live addr", r, 0);
    rd(4'd9, r);  chk(r == 0, "R1 live inner", r, 0);
    rd(4'd10, r); chk(r == 0, "R1 live outer", r, 0);
    chk(!req_valid && !irq, "R1 outputs idle", {30'd0, req_valid, irq}, 0);

    // vector table: R3 flat, R4 2D, R5 negative and zero strides
    for (int v = 0; v < NV; v++) begin
      run_pattern(VEC[v][111:80], VEC[v][79:64], VEC[v][63:48], VEC[v][47:32],
                  VEC[v][31:16], VEC[v][15:0],
                  (v == 3 || v == 4) ? "R5 stride pattern" :
                  (v == 2 ? "R4 row walk" : "R3 flat walk"), 1'b1);
    end

    // R6 count 0 means 65536
    run_pattern(32'h0001_0000, 16'd0, 16'h0001, 16'd0, 16'h0, 16'h0041,
                "R6 full 65536 beats", 1'b0);
    // R6 outer count 0 in 2D (65536 rows of 1)
    run_pattern(32'h0002_0000, 16'd1, 16'h0001, 16'd0, 16'h0002, 16'h0051,
                "R6 full 65536 rows", 1'b0);

    // R8 interrupt mode 0 keeps irq low
    run_pattern(32'h0000_6000, 16'd2, 16'h0001, 16'd0, 16'h0, 16'h0001,
                "R8 mode zero run", 1'b1);

    // R9 write-one-to-clear, bitwise
    setup(32'h0000_7000, 16'd1, 16'h1, 16'd0, 16'h0);
    wr(4'd5, 32'h0041);
    repeat (4) @(negedge clk);
    wr(4'd6, 32'h2);
    rd(4'd6, r); chk(r[1:0] == 2'b01, "R9 clear err leaves done", r, 1);
    wr(4'd6, 32'h1);
    rd(4'd6, r); chk(r[1:0] == 2'b00 && !irq, "R9 clear done", {r[30:0], irq}, 0);
    cleanup();

    // R10 size code 3
    setup(32'h0000_8000, 16'd4, 16'h4, 16'd0, 16'h0);
    wr(4'd5, 32'h004D);
    seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (req_valid) seen = 1'b1;
      @(negedge clk);
    end
    rd(4'd6, r);
    chk(r[1] && !seen && irq, "R10 size 3 error", {r[30:0], seen}, 32'h4);
    cleanup();

    // R10 misaligned base
    setup(32'h0000_8001, 16'd4, 16'h2, 16'd0, 16'h0);
    wr(4'd5, 32'h0045);
    seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (req_valid) seen = 1'b1;
      @(negedge clk);
    end
    rd(4'd6, r);
    chk(r[1:0] == 2'b10 && !seen, "R10 misaligned base", {r[30:0], seen}, 32'h4);
    cleanup();

    // R10 misalignment reached through the stride: one beat then error
    setup(32'h0000_9000, 16'd4, 16'h2, 16'd0, 16'h0);
    wr(4'd5, 32'h0049);
    @(negedge clk);
    chk(req_valid && req_addr == 32'h9000, "R10 aligned first beat", req_addr, 32'h9000);
    @(negedge clk);
    chk(!req_valid, "R10 misaligned beat withheld", {31'd0, req_valid}, 0);
    @(negedge clk);
    rd(4'd6, r);
    chk(r[1:0] == 2'b10, "R10 stride error bit", r, 2);
    cleanup();

    // R13 stall holds address
    setup(32'h0000_A000, 16'd3, 16'h1, 16'd0, 16'h0);
    req_ready = 1'b0;
    wr(4'd5, 32'h0001);
    @(negedge clk);
    a0 = req_addr;
    repeat (3) @(negedge clk);
    chk(req_valid && req_addr == a0 && a0 == 32'hA000, "R13 stalled hold", req_addr, 32'hA000);
    req_ready = 1'b1;
    @(negedge clk);
    chk(req_valid && req_addr == 32'hA001, "R13 advance after accept", req_addr, 32'hA001);

    // R11 halt mid-pattern
    wr(4'd5, 32'h0000);
    chk(!req_valid, "R11 halt drops valid", {31'd0, req_valid}, 0);
    repeat (3) @(negedge clk);
    rd(4'd6, r);
    chk(!req_valid && r[0] == 1'b0, "R11 stays halted", {r[30:0], req_valid}, 0);

    // R12 flush clears live state
    setup(32'h0000_B000, 16'd8, 16'h1, 16'd0, 16'h0);
    wr(4'd5, 32'h0001);
    repeat (3) @(negedge clk);
    wr(4'd5, 32'h0021);
    @(negedge clk);
    rd(4'd8, r);  chk(r == 0, "R12 live addr flushed", r, 0);
    rd(4'd9, r);  chk(r == 0, "R12 live inner flushed", r, 0);
    rd(4'd10, r); chk(r == 0 && !req_valid, "R12 live outer flushed", {r[30:0], req_valid}, 0);
    cleanup();

    finish_run();
  end
endmodule